// File: doc/BRIEF.md
# Ordered Posted-Write Buffer with Barrier and Timed Drains

This block sits between the store port of a single core and a downstream memory port. Stores are accepted at once and held in a small age-ordered queue. Nothing reaches the downstream port until there is a reason to release it. A reason is one of four things: a barrier request, expiry of a programmable drain interval, a full queue, or a read that must not overtake buffered stores. Every store carries a memory-type tag. Normal stores to an address that is already buffered are combined into the existing entry. Device and Strongly Ordered stores always take their own slot and are never combined.

On the load side, a Normal load whose address matches a fully written buffered entry is answered in the same cycle from the buffer. A Device or Strongly Ordered load is never answered from the buffer. It is held back until no store of its own type remains queued, and then it goes downstream. Loads of one type are not held back by stores of another type. Load data from downstream returns to the core outside this block. Only the load request passes through here.

Top module: `posted_write_buffer`

## Requirements
- R1: A buffered store appears on the downstream port (ds_valid=1, ds_write=1) only while one of these holds: a barrier is outstanding, a timed drain is active, the queue is full, or a load is waiting on the buffer.
- R2: When cfg_interval is N (non-zero), the drain timer expires N cycles after its last restart and empties the whole queue. The timer restarts from zero once any drain completes, whether a barrier or the timer started it.
- R3: When cfg_interval is zero, no timed drain ever starts, and buffered stores stay put indefinitely.
- R4: A one-cycle bar_req makes wr_ready low from the next cycle. bar_done then pulses for exactly one cycle, and only after every entry has been accepted downstream. This also happens when the queue is already empty.
- R5: Memory type is encoded as 0 Normal, 1 Device, 2 Strongly Ordered. A type 1 or type 2 store always takes a new entry, even when its address repeats, and each such store leaves separately in arrival order.
- R6: A Normal store to an address held by a Normal entry updates that entry in place. Only the bytes whose enable bit b is set change, and bit b covers data bits 8b+7 down to 8b. No new entry is taken.
- R7: A Normal load (rd_type 0) that matches a Normal entry with all byte enables set gets rd_ready=1, rd_hit=1 and the entry's data in the same cycle. It issues no downstream read.
- R8: A type 1 or type 2 load goes downstream (ds_write=0) only after every queued store of that same type has been accepted. A Normal load that misses goes downstream at once, even while Device stores are queued.
- R9: Stores leave the queue oldest first.
- R10: With 8 entries occupied, a store that cannot merge sees wr_ready low. The oldest entries are then released until a slot frees, and the store is accepted.
- R11: A Normal load that matches a partially written Normal entry is not answered from the buffer. The queue releases stores until that entry has gone, and then the load goes downstream.
- R12: While a downstream store is stalled by ds_ready low, its address, data and byte enables hold steady for as long as it stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_interval | input | TW | Cycles between timed drains; 0 disables them |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Store accepted this cycle |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_be | input | DW/8 | Store byte enables |
| wr_type | input | 2 | Store memory type |
| rd_valid | input | 1 | Load request valid |
| rd_ready | output | 1 | Load answered or passed downstream |
| rd_addr | input | AW | Load address |
| rd_type | input | 2 | Load memory type |
| rd_hit | output | 1 | Load answered from the buffer this cycle |
| rd_hit_data | output | DW | Buffered data for a hit |
| bar_req | input | 1 | Barrier request pulse |
| bar_done | output | 1 | One-cycle barrier completion |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream accepts request |
| ds_write | output | 1 | 1 store, 0 load |
| ds_addr | output | AW | Downstream address |
| ds_data | output | DW | Downstream store data |
| ds_be | output | DW/8 | Downstream byte enables |
| ds_type | output | 2 | Downstream memory type |

## Verification
The assertions rely on several assumptions about the inputs. Type code 3 is never driven. A new bar_req is never raised while a barrier is outstanding or in the cycle bar_done pulses, so each done pulse stands alone. Load and store requests are held until their ready is seen. The directed tasks keep to all of this: each barrier is a single-cycle pulse followed by a wait that outlasts its completion, and each request is held and dropped only after its handshake. Backpressure on ds_ready is toggled only during the ordering scenario, so the stability check on stalled stores gets exercised.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [1:0] {
      MT_NORMAL = 2'd0,
      MT_DEVICE = 2'd1,
      MT_STRONG = 2'd2,
      MT_RSVD   = 2'd3
   } mem_type_e;
endpackage

// File: rtl/wbuf_lookup.sv
module wbuf_lookup #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DEPTH-1:0]          cand,
   input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
   input  logic [AW-1:0]             key,
   output logic                      hit,
   output logic [IW-1:0]             idx
);
   logic [DEPTH-1:0] match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = cand[i] && (ent_addr[i] == key);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match[i]) idx = IW'(i);
   end

   assign hit = |match;

   // R6: merging keeps one Normal entry per address
   p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/wbuf_drain_timer.sv
module wbuf_drain_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] interval,
   input  logic          hold,
   input  logic          restart,
   output logic          expire
);
   logic [TW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (interval != '0) && (cnt_q >= interval - TW'(1));
   assign expire = !hold && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (restart)                    cnt_q <= '0;
      else if (!hold && interval != '0)    cnt_q <= at_end ? '0 : cnt_q + TW'(1);
   end
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer
   import wbuf_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TW-1:0]     cfg_interval,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [DW/8-1:0]   wr_be,
   input  logic [1:0]        wr_type,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [AW-1:0]     rd_addr,
   input  logic [1:0]        rd_type,
   output logic              rd_hit,
   output logic [DW-1:0]     rd_hit_data,
   input  logic              bar_req,
   output logic              bar_done,
   output logic              ds_valid,
   input  logic              ds_ready,
   output logic              ds_write,
   output logic [AW-1:0]     ds_addr,
   output logic [DW-1:0]     ds_data,
   output logic [DW/8-1:0]   ds_be,
   output logic [1:0]        ds_type
);
   localparam int BW = DW / 8;
   localparam int IW = $clog2(DEPTH);
   localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (TW < 2) begin : g_bad_tw
      $error("TW must be at least 2");
   end

   logic [DEPTH-1:0]           vld_q;
   logic [DEPTH-1:0][AW-1:0]   addr_q;
   logic [DEPTH-1:0][DW-1:0]   data_q;
   logic [DEPTH-1:0][BW-1:0]   be_q;
   logic [DEPTH-1:0][1:0]      type_q;
   logic [IW-1:0]              head_q, tail_q;
   logic [IW:0]                cnt_q, dev_n, so_n;
   logic                       bar_pend_q, drain_all_q;

   logic [DEPTH-1:0] norm_vec;
   logic             wr_hit, rd_m;
   logic [IW-1:0]    wr_idx, rd_idx;
   logic             full, empty, wr_merge, rd_full_hit, rd_part_hit;
   logic             rd_type_busy, rd_drain, full_press, want_pop, pop_act;
   logic             head_busy, rd_go_ds, pop_fire, wr_fire, alloc, merge;
   logic             expire, tmr_restart;

   always_comb begin
      dev_n = '0;
      so_n  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         norm_vec[i] = vld_q[i] && (type_q[i] == MT_NORMAL);
         if (vld_q[i] && type_q[i] == MT_DEVICE) dev_n = dev_n + (IW+1)'(1);
         if (vld_q[i] && type_q[i] != MT_NORMAL && type_q[i] != MT_DEVICE)
            so_n = so_n + (IW+1)'(1);
      end
   end

   wbuf_lookup #(.DEPTH(DEPTH), .AW(AW)) u_wr_lookup (
      .clk(clk), .rst_n(rst_n), .cand(norm_vec), .ent_addr(addr_q),
      .key(wr_addr), .hit(wr_hit), .idx(wr_idx));

   wbuf_lookup #(.DEPTH(DEPTH), .AW(AW)) u_rd_lookup (
      .clk(clk), .rst_n(rst_n), .cand(norm_vec), .ent_addr(addr_q),
      .key(rd_addr), .hit(rd_m), .idx(rd_idx));

   assign full         = (cnt_q == FULL_CNT);
   assign empty        = (cnt_q == '0);
   assign wr_merge     = (wr_type == MT_NORMAL) && wr_hit;
   assign rd_full_hit  = rd_valid && (rd_type == MT_NORMAL) && rd_m && (&be_q[rd_idx]);
   assign rd_part_hit  = rd_valid && (rd_type == MT_NORMAL) && rd_m && !(&be_q[rd_idx]);
   assign rd_type_busy = rd_valid && (((rd_type == MT_DEVICE) && dev_n != '0) ||
                         ((rd_type != MT_NORMAL) && (rd_type != MT_DEVICE) && so_n != '0));
   assign rd_drain     = rd_part_hit || rd_type_busy;
   assign full_press   = wr_valid && full && !wr_merge && !bar_pend_q;
   assign want_pop     = drain_all_q || bar_pend_q || full_press || rd_drain;
   assign pop_act      = want_pop && !empty;
   assign head_busy    = wr_merge && (wr_idx == head_q) && pop_act;
   assign rd_go_ds     = rd_valid && !rd_full_hit && !rd_drain && !pop_act;

   assign wr_ready    = !bar_pend_q && (wr_merge ? !head_busy : !full);
   assign rd_ready    = rd_full_hit || (rd_go_ds && ds_ready);
   assign rd_hit      = rd_full_hit;
   assign rd_hit_data = rd_full_hit ? data_q[rd_idx] : '0;
   assign bar_done    = bar_pend_q && empty;

   assign ds_valid = pop_act || rd_go_ds;
   assign ds_write = pop_act;
   assign ds_addr  = pop_act ? addr_q[head_q] : rd_addr;
   assign ds_data  = pop_act ? data_q[head_q] : '0;
   assign ds_be    = pop_act ? be_q[head_q]   : '1;
   assign ds_type  = pop_act ? type_q[head_q] : rd_type;

   assign pop_fire = pop_act && ds_ready;
   assign wr_fire  = wr_valid && wr_ready;
   assign alloc    = wr_fire && !wr_merge;
   assign merge    = wr_fire && wr_merge;

   assign tmr_restart = bar_done || (drain_all_q && empty);

   wbuf_drain_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .interval(cfg_interval),
      .hold(drain_all_q || bar_pend_q), .restart(tmr_restart), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q       <= '0;
         addr_q      <= '0;
         data_q      <= '0;
         be_q        <= '0;
         type_q      <= '0;
         head_q      <= '0;
         tail_q      <= '0;
         cnt_q       <= '0;
         bar_pend_q  <= 1'b0;
         drain_all_q <= 1'b0;
      end else begin
         bar_pend_q <= bar_req || (bar_pend_q && !bar_done);
         if (drain_all_q && empty) drain_all_q <= 1'b0;
         else if (expire)          drain_all_q <= 1'b1;
         if (merge) begin
            for (int b = 0; b < BW; b++)
               if (wr_be[b]) data_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            be_q[wr_idx] <= be_q[wr_idx] | wr_be;
         end
         if (pop_fire) begin
            vld_q[head_q] <= 1'b0;
            head_q        <= head_q + IW'(1);
         end
         if (alloc) begin
            vld_q[tail_q]  <= 1'b1;
            addr_q[tail_q] <= wr_addr;
            data_q[tail_q] <= wr_data;
            be_q[tail_q]   <= wr_be;
            type_q[tail_q] <= wr_type;
            tail_q         <= tail_q + IW'(1);
         end
         cnt_q <= cnt_q + (IW+1)'(alloc) - (IW+1)'(pop_fire);
      end
   end

   // R1: stores go out only for a drain reason
   p_no_early_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_valid && ds_write) |-> (drain_all_q || bar_pend_q || full || rd_valid));
   // R3: a zero interval never starts a timed drain
   p_zero_interval_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_interval == '0 && !drain_all_q) |=> !drain_all_q);
   // R4: barrier stalls stores, done is a single pulse
   p_bar_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bar_req |=> !wr_ready);
   p_bar_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bar_done |=> !bar_done);
   // R5: a Device or Strongly Ordered store always takes a fresh entry
   p_dev_no_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_type != MT_NORMAL && !pop_fire)
      |=> cnt_q == $past(cnt_q) + (IW+1)'(1));
   // R7: a buffer hit issues no downstream load
   p_hit_no_ds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> !(ds_valid && !ds_write));
   // R8: Device load only once no Device store is queued
   p_dev_read_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_valid && !ds_write && ds_type == MT_DEVICE) |-> dev_n == '0);
   // R10: occupancy never exceeds the depth
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);
   // R12: a stalled downstream store stays steady
   p_ds_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_valid && ds_write && !ds_ready) |=>
      (!(ds_valid && ds_write) || ($stable(ds_addr) && $stable(ds_data) && $stable(ds_be))));
endmodule

// File: tb/posted_write_buffer_bench.sv
`timescale 1ns/1ps
module posted_write_buffer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_interval = '0;
   logic        wr_valid = 1'b0, rd_valid = 1'b0, bar_req = 1'b0, ds_ready = 1'b1;
   logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
   logic [3:0]  wr_be = '0;
   logic [1:0]  wr_type = '0, rd_type = '0;
   logic        wr_ready, rd_ready, rd_hit, bar_done, ds_valid, ds_write;
   logic [31:0] rd_hit_data, ds_addr, ds_data;
   logic [3:0]  ds_be;
   logic [1:0]  ds_type;

   int n_chk = 0, n_fail = 0, cyc = 0, log_n = 0;
   logic        stall_en = 1'b0;
   logic        lg_w [64];
   logic [31:0] lg_a [64];
   logic [31:0] lg_d [64];
   logic [1:0]  lg_t [64];

   always #2.5 clk = ~clk;

   posted_write_buffer u_posted_write_buffer (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .wr_type(wr_type), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_addr(rd_addr), .rd_type(rd_type), .rd_hit(rd_hit), .rd_hit_data(rd_hit_data),
      .bar_req(bar_req), .bar_done(bar_done), .ds_valid(ds_valid), .ds_ready(ds_ready),
      .ds_write(ds_write), .ds_addr(ds_addr), .ds_data(ds_data), .ds_be(ds_be),
      .ds_type(ds_type));

   always @(posedge clk) begin
      if (ds_valid && ds_ready && log_n < 64) begin
         lg_w[log_n] = ds_write;
         lg_a[log_n] = ds_addr;
         lg_d[log_n] = ds_data;
         lg_t[log_n] = ds_type;
         log_n = log_n + 1;
      end
   end

   always @(negedge clk) ds_ready <= stall_en ? ~ds_ready : 1'b1;

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [31:0] a, logic [31:0] d, logic [3:0] be, logic [1:0] t);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be; wr_type = t;
      #1;
      while (!wr_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      wr_valid = 1'b0;
   endtask

   task automatic do_read(logic [31:0] a, logic [1:0] t, output logic hit, output logic [31:0] d);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a; rd_type = t;
      #1;
      while (!rd_ready) begin @(negedge clk); #1; end
      hit = rd_hit; d = rd_hit_data;
      @(posedge clk); #1;
      rd_valid = 1'b0;
   endtask

   task automatic do_barrier(output int pulses);
      pulses = 0;
      @(negedge clk); bar_req = 1'b1;
      @(negedge clk); bar_req = 1'b0;
      #1;
      chk("R4", "wr_ready during barrier", wr_ready, 0);
      for (int i = 0; i < 120; i++) begin
         if (bar_done) pulses++;
         @(negedge clk); #1;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "ds_valid after reset", ds_valid, 0);
      chk("R4", "bar_done after reset", bar_done, 0);
      chk("R10", "wr_ready after reset", wr_ready, 1);
      chk("R7", "rd_hit after reset", rd_hit, 0);
   endtask

   task automatic t_hold_and_merge();
      logic h; logic [31:0] d; int p; int base;
      base = log_n;
      do_write(32'h100, 32'h1111_1111, 4'hF, 2'd0);
      do_write(32'h104, 32'h2222_2222, 4'hF, 2'd0);
      do_write(32'h108, 32'h3333_3333, 4'hF, 2'd0);
      idle(50);
      chk("R3", "no timed drain with zero interval", log_n - base, 0);
      chk("R1", "stores held without reason", log_n - base, 0);
      do_write(32'h100, 32'h0000_00AA, 4'h1, 2'd0);
      do_read(32'h100, 2'd0, h, d);
      chk("R7", "full-mask hit flag", h, 1);
      chk("R6", "merged data under byte mask", d, 32'h1111_11AA);
      chk("R7", "hit issues no downstream load", log_n - base, 0);
      do_barrier(p);
      chk("R4", "barrier done pulses", p, 1);
      chk("R6", "merge took no extra entry", log_n - base, 3);
      chk("R9", "oldest first 0", lg_a[base], 32'h100);
      chk("R6", "merged data downstream", lg_d[base], 32'h1111_11AA);
      chk("R9", "oldest first 1", lg_a[base+1], 32'h104);
      chk("R9", "oldest first 2", lg_a[base+2], 32'h108);
   endtask

   task automatic t_no_merge_dev();
      int p; int base;
      base = log_n;
      do_write(32'h200, 32'hD1, 4'hF, 2'd1);
      do_write(32'h200, 32'hD2, 4'hF, 2'd1);
      do_write(32'h204, 32'hE1, 4'hF, 2'd2);
      do_write(32'h204, 32'hE2, 4'hF, 2'd2);
      do_barrier(p);
      chk("R5", "each strict store separate", log_n - base, 4);
      chk("R5", "device order first", lg_d[base], 32'hD1);
      chk("R5", "device order second", lg_d[base+1], 32'hD2);
      chk("R5", "strong order first", lg_d[base+2], 32'hE1);
      chk("R5", "strong order second", lg_d[base+3], 32'hE2);
      chk("R5", "strong type code", lg_t[base+3], 2'd2);
   endtask

   task automatic t_dev_read();
      logic h; logic [31:0] d; int p; int base;
      stall_en = 1'b1;
      base = log_n;
      do_write(32'h300, 32'hA1, 4'hF, 2'd1);
      do_write(32'h310, 32'hB1, 4'hF, 2'd0);
      do_write(32'h300, 32'hA2, 4'hF, 2'd1);
      do_read(32'h360, 2'd1, h, d);
      idle(2);
      chk("R8", "entries before device load", log_n - base, 4);
      chk("R8", "device store first", lg_d[base], 32'hA1);
      chk("R8", "second device store drained", lg_d[base+2], 32'hA2);
      chk("R8", "load issued last", lg_w[base+3], 0);
      chk("R8", "load address", lg_a[base+3], 32'h360);
      chk("R7", "strict load not hit", h, 0);
      base = log_n;
      do_write(32'h380, 32'hC1, 4'hF, 2'd1);
      do_read(32'h390, 2'd0, h, d);
      idle(2);
      chk("R8", "normal miss passes device store", log_n - base, 1);
      chk("R8", "normal miss is a load", lg_w[base], 0);
      stall_en = 1'b0;
      do_barrier(p);
      chk("R8", "device store after barrier", lg_d[log_n-1], 32'hC1);
   endtask

   task automatic t_partial_hit();
      logic h; logic [31:0] d; int base;
      base = log_n;
      do_write(32'h400, 32'h0000_1234, 4'h3, 2'd0);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = 32'h400; rd_type = 2'd0;
      #1;
      chk("R11", "partial entry not forwarded", rd_hit, 0);
      while (!rd_ready) begin @(negedge clk); #1; end
      h = rd_hit;
      @(posedge clk); #1;
      rd_valid = 1'b0;
      idle(2);
      chk("R11", "partial store drained then load", log_n - base, 2);
      chk("R11", "first is the store", lg_w[base], 1);
      chk("R11", "then the load", lg_w[base+1], 0);
      chk("R11", "no hit on completion", h, 0);
   endtask

   task automatic t_full();
      int p; int base;
      base = log_n;
      for (int i = 0; i < 8; i++) do_write(32'h500 + 32'(i*4), 32'(i), 4'hF, 2'd0);
      chk("R10", "nothing out while filling", log_n - base, 0);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 32'h5F0; wr_data = 32'h99; wr_be = 4'hF; wr_type = 2'd0;
      #1;
      chk("R10", "wr_ready low when full", wr_ready, 0);
      while (!wr_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      wr_valid = 1'b0;
      chk("R10", "one slot freed", log_n - base, 1);
      chk("R10", "oldest released", lg_a[base], 32'h500);
      do_barrier(p);
      chk("R9", "all released", log_n - base, 9);
      chk("R9", "last is newest", lg_a[base+8], 32'h5F0);
   endtask

   task automatic t_timed();
      int base; int seen;
      @(negedge clk); cfg_interval = 16'd16;
      base = log_n;
      do_write(32'h600, 32'h61, 4'hF, 2'd0);
      idle(8);
      chk("R1", "held before interval", log_n - base, 0);
      seen = 0;
      for (int i = 0; i < 30 && seen == 0; i++) begin
         @(negedge clk);
         if (log_n != base) seen = 1;
      end
      chk("R2", "timed drain released store", seen, 1);
      idle(3);
      base = log_n;
      do_write(32'h604, 32'h62, 4'hF, 2'd0);
      idle(8);
      chk("R2", "timer restarted after drain", log_n - base, 0);
      seen = 0;
      for (int i = 0; i < 30 && seen == 0; i++) begin
         @(negedge clk);
         if (log_n != base) seen = 1;
      end
      chk("R2", "second timed drain", seen, 1);
      @(negedge clk); cfg_interval = '0;
   endtask

   task automatic t_empty_barrier();
      int p;
      do_barrier(p);
      chk("R4", "empty barrier single pulse", p, 1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hold_and_merge();
      t_no_merge_dev();
      t_dev_read();
      t_partial_hit();
      t_full();
      t_timed();
      t_empty_barrier();
      summary();
      $finish;
   end
endmodule